// File: doc/BRIEF.md
# Write-Completion Status Readback

This block sits on the read path of a byte-lane non-volatile memory. While a lane's internal write cycle is running, the array contents of that lane cannot be read. For that time the block replaces the read data with two status indications that a host can poll. Bit 7 of a lane byte carries the inverse of the value last written, but only when the read hits the last written address. Bit 6 of the lane byte flips once after every completed read. When the lane's busy flag drops, reads return true array data at once.

Each lane has its own busy flag and its own toggle state. A lane that is not busy passes its array byte through unchanged. The output bus is driven only for a qualified read, which needs chip enable low, output enable low and write enable high. In every other case the bus is marked as not driven and reads zero.

The block looks only at the busy flag. It does not know why a lane is busy. A write that protection rejects still runs the write timer, so polling reads during that time behave exactly like polling reads after an accepted write.

Top module: `wr_status_readback`

## Requirements
- R1: `data_oe_o` is 1 only when `ce_ni`=0, `oe_ni`=0 and `we_ni`=1. In every other case `data_oe_o`=0 and `data_o` is all zeros.
- R2: For a qualified read, a lane whose busy bit is 0 returns its array byte unchanged. The change is visible in the same cycle the busy bit falls.
- R3: For a qualified read on a busy lane where `rd_addr_i` equals `last_addr_i`, bit 7 of the lane byte is the inverse of bit 7 of that lane's last written byte.
- R4: For a qualified read on a busy lane where the addresses differ, bit 7 of the lane byte is the true bit 7 of the last written byte.
- R5: On a busy lane, bits 5..0 of the lane byte are bits 5..0 of the last written byte, and the array byte has no effect. Lane l occupies bits 8l+7..8l.
- R6: On a busy lane, bit 6 shows that lane's toggle state. The toggle state is held at 0 while the lane is idle, so every busy period starts with bit 6 = 0, including the period right after reset.
- R7: The toggle state of a busy lane inverts exactly once per completed read: a qualified `rd_strobe_i` high for one or more cycles and then low. The inversion is visible one clock edge after the strobe falls, and it does not depend on how long the strobe was high.
- R8: A strobe raised while the read is not qualified, or a strobe on a lane that is idle, leaves the toggle state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | LANES | Per-lane write cycle in progress |
| last_addr_i | input | ADDR_W | Address of the last write |
| last_data_i | input | LANES*8 | Data of the last write, one byte per lane |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| rd_strobe_i | input | 1 | High for the duration of one read access |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | LANES*8 | Data read from the array |
| data_o | output | LANES*8 | Read data returned to the host |
| data_oe_o | output | 1 | Output bus driven; 0 means high impedance |

## Verification
The only internal state is one toggle bit per lane and the registered read strobe. If either is wrong, it shows at the ports through bit 6 of a busy lane on the next qualified read. A stuck toggle shows up after a single completed strobe. A toggle that flips per clock instead of per read shows up during a strobe held for several cycles. A toggle not cleared between busy periods shows up on the first read of the next period. Faults in the selection between the polling byte and the array byte, or in the address comparison, are combinational. They appear on bit 7 or on the low bits in the same cycle as the read.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned LOW_W    = TOG_BIT;

  typedef logic [LANE_W-1:0] lane_t;

  // status byte shown while a lane is busy
  function automatic lane_t poll_byte(input lane_t last_b, input logic addr_hit,
                                      input logic tog);
    lane_t r;
    r = last_b;
    r[POLL_BIT] = addr_hit ? ~last_b[POLL_BIT] : last_b[POLL_BIT];
    r[TOG_BIT]  = tog;
    return r;
  endfunction
endpackage

// File: rtl/rd_qualify.sv
module rd_qualify (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic rd_strobe_i,
  output logic rd_en_o,
  output logic rd_done_o
);
  logic qual;
  logic qual_q;

  assign rd_en_o = ~ce_ni & ~oe_ni & we_ni;
  assign qual    = rd_strobe_i & rd_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= 1'b0;
    else         qual_q <= qual;
  end

  // a read completes when its qualified strobe ends
  assign rd_done_o = qual_q & ~qual;
endmodule

// File: rtl/toggle_lane.sv
module toggle_lane #(
  parameter logic TOG_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_done_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tog_q <= TOG_INIT;
    else if (!busy_i)   tog_q <= TOG_INIT;
    else if (rd_done_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/poll_lane_mux.sv
module poll_lane_mux
  import wr_status_pkg::*;
(
  input  logic  busy_i,
  input  logic  addr_hit_i,
  input  logic  tog_i,
  input  lane_t last_i,
  input  lane_t array_i,
  output lane_t byte_o
);
  always_comb begin
    if (busy_i) byte_o = poll_byte(last_i, addr_hit_i, tog_i);
    else        byte_o = array_i;
  end
endmodule

// File: rtl/wr_status_readback.sv
module wr_status_readback
  import wr_status_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 17,
  parameter logic        TOG_INIT = 1'b0,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  busy_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              rd_strobe_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              rd_en;
  logic              rd_done;
  logic              addr_hit;
  logic [LANES-1:0]  lane_tog;
  logic [DATA_W-1:0] lane_bus;

  rd_qualify i_rd_qualify (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .rd_strobe_i(rd_strobe_i),
    .rd_en_o    (rd_en),
    .rd_done_o  (rd_done)
  );

  assign addr_hit = (rd_addr_i == last_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    toggle_lane #(.TOG_INIT(TOG_INIT)) i_toggle_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .busy_i   (busy_i[l]),
      .rd_done_i(rd_done),
      .tog_o    (lane_tog[l])
    );

    poll_lane_mux i_poll_lane_mux (
      .busy_i    (busy_i[l]),
      .addr_hit_i(addr_hit),
      .tog_i     (lane_tog[l]),
      .last_i    (last_data_i[l*LANE_W +: LANE_W]),
      .array_i   (array_data_i[l*LANE_W +: LANE_W]),
      .byte_o    (lane_bus[l*LANE_W +: LANE_W])
    );
  end

  assign data_oe_o = rd_en;
  assign data_o    = rd_en ? lane_bus : '0;
endmodule

// File: rtl/wr_status_readback_chk.sv
module wr_status_readback_chk
  import wr_status_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 17,
  parameter logic        TOG_INIT = 1'b0,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LANES-1:0]  busy_i,
  input logic [ADDR_W-1:0] last_addr_i,
  input logic [DATA_W-1:0] last_data_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              rd_strobe_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [LANES-1:0]  lane_tog
);
  logic en_c, qual_c, qual_q, done_c, hit_c;

  assign en_c   = ~ce_ni & ~oe_ni & we_ni;
  assign qual_c = rd_strobe_i & en_c;
  assign hit_c  = (rd_addr_i == last_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= 1'b0;
    else         qual_q <= qual_c;
  end
  assign done_c = qual_q & ~qual_c;

  a_r1_bus_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_c |-> (!data_oe_o && data_o == '0));

  a_r1_bus_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_c |-> data_oe_o);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r2_idle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_c && !busy_i[l]) |->
        data_o[l*LANE_W +: LANE_W] == array_data_i[l*LANE_W +: LANE_W]);

    a_r3_poll_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_c && busy_i[l] && hit_c) |->
        data_o[l*LANE_W + POLL_BIT] != last_data_i[l*LANE_W + POLL_BIT]);

    a_r4_poll_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_c && busy_i[l] && !hit_c) |->
        data_o[l*LANE_W + POLL_BIT] == last_data_i[l*LANE_W + POLL_BIT]);

    a_r5_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_c && busy_i[l]) |->
        data_o[l*LANE_W +: LOW_W] == last_data_i[l*LANE_W +: LOW_W]);

    a_r6_fresh_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_c && $rose(busy_i[l])) |-> data_o[l*LANE_W + TOG_BIT] == TOG_INIT);

    a_r7_flip_per_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i[l] && $past(busy_i[l])) |->
        lane_tog[l] == ($past(lane_tog[l]) ^ $past(done_c)));
  end
endmodule

bind wr_status_readback wr_status_readback_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .TOG_INIT(TOG_INIT)
) i_wr_status_readback_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_i),
  .last_addr_i (last_addr_i),
  .last_data_i (last_data_i),
  .ce_ni       (ce_ni),
  .oe_ni       (oe_ni),
  .we_ni       (we_ni),
  .rd_strobe_i (rd_strobe_i),
  .rd_addr_i   (rd_addr_i),
  .array_data_i(array_data_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .lane_tog    (lane_tog)
);

// File: tb/test_wr_status_readback.sv
module test_wr_status_readback;
  localparam int unsigned LANES  = 4;
  localparam int unsigned ADDR_W = 17;
  localparam int unsigned DW     = LANES * 8;
  localparam logic [ADDR_W-1:0] LADDR = 17'h1_2345;

  typedef struct packed {
    logic [3:0]  busy;
    logic        ce_n;
    logic        oe_n;
    logic        we_n;
    logic        hit;
    logic [31:0] ldata;
    logic [31:0] adata;
    logic [31:0] exp_d;
    logic        exp_oe;
  } vec_t;

  // R2 idle, R3/R5 hit, R4 miss, per-lane mix, R1 disables, R5 array ignored
  localparam vec_t TBL [0:7] = '{
    '{4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFF00_807F, 32'h1234_5678, 32'h1234_5678, 1'b1},
    '{4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFF00_807F, 32'h1234_5678, 32'h3F80_00BF, 1'b1},
    '{4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFF00_807F, 32'h0000_0000, 32'hBF00_803F, 1'b1},
    '{4'h5, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFF00_807F, 32'h1122_3344, 32'h1180_33BF, 1'b1},
    '{4'hF, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFF00_807F, 32'h1122_3344, 32'h0000_0000, 1'b0},
    '{4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFF00_807F, 32'h1122_3344, 32'h0000_0000, 1'b0},
    '{4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 32'hFF00_807F, 32'h1122_3344, 32'h0000_0000, 1'b0},
    '{4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00FF_7F80, 32'hFFFF_FFFF, 32'h803F_BF00, 1'b1}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [LANES-1:0]  busy_i = '0;
  logic [ADDR_W-1:0] last_addr_i = LADDR;
  logic [DW-1:0]     last_data_i = '0;
  logic              ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic              rd_strobe_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = LADDR;
  logic [DW-1:0]     array_data_i = '0;
  logic [DW-1:0]     data_o;
  logic              data_oe_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wr_status_readback #(.LANES(LANES), .ADDR_W(ADDR_W)) i_wr_status_readback (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .last_addr_i(last_addr_i),
    .last_data_i(last_data_i), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .rd_strobe_i(rd_strobe_i), .rd_addr_i(rd_addr_i), .array_data_i(array_data_i),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] exp_d, input logic exp_oe);
    checks++;
    if (data_o !== exp_d || data_oe_o !== exp_oe) begin
      errors++;
      $display("FAIL %s: data_o=%h oe=%b expected data_o=%h oe=%b",
               tag, data_o, data_oe_o, exp_d, exp_oe);
    end
  endtask

  task automatic enable_rd();
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1;
  endtask

  // strobe high for n cycles, then low; inversion visible one edge later
  task automatic read_pulse(input int n);
    @(negedge clk_i); rd_strobe_i = 1'b1;
    for (int k = 0; k < n; k++) @(negedge clk_i);
    rd_strobe_i = 1'b0;
    @(negedge clk_i); #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // reset: bus off, then busy lanes start with toggle 0 (R1, R6)
    last_data_i = 32'hFF00_807F;
    busy_i = 4'hF;
    repeat (3) @(negedge clk_i);
    #1 check("R1 reset bus off", '0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    enable_rd();
    #1 check("R6 toggle after reset", 32'h3F80_00BF, 1'b1);

    // vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      busy_i = TBL[i].busy;
      ce_ni = TBL[i].ce_n; oe_ni = TBL[i].oe_n; we_ni = TBL[i].we_n;
      last_data_i = TBL[i].ldata;
      array_data_i = TBL[i].adata;
      rd_addr_i = TBL[i].hit ? LADDR : (LADDR ^ 17'h1);
      #1 check($sformatf("table %0d R1 R2 R3 R4 R5", i), TBL[i].exp_d, TBL[i].exp_oe);
    end

    // R7 single-cycle read
    @(negedge clk_i);
    busy_i = 4'hF; enable_rd(); rd_addr_i = LADDR;
    last_data_i = 32'hFF00_807F; array_data_i = 32'h1234_5678;
    read_pulse(1);
    check("R7 flip after one read", 32'h7FC0_40FF, 1'b1);

    // R7 long strobe: no flip mid-read, one flip at the end
    @(negedge clk_i); rd_strobe_i = 1'b1;
    repeat (3) @(negedge clk_i);
    #1 check("R7 no flip during held strobe", 32'h7FC0_40FF, 1'b1);
    rd_strobe_i = 1'b0;
    @(negedge clk_i); #1;
    check("R7 single flip for long read", 32'h3F80_00BF, 1'b1);

    // R8 strobe while not qualified
    @(negedge clk_i); oe_ni = 1'b1;
    read_pulse(2);
    enable_rd();
    #1 check("R8 unqualified strobe ignored", 32'h3F80_00BF, 1'b1);

    // R2 completion returns array data in the same cycle
    @(negedge clk_i); busy_i = 4'h0; array_data_i = 32'hCAFE_BABE;
    #1 check("R2 true data on completion", 32'hCAFE_BABE, 1'b1);

    // R8 idle lanes do not toggle; only lane 0 busy
    @(negedge clk_i); busy_i = 4'h1;
    read_pulse(1);
    busy_i = 4'hF;
    #1 check("R8 idle lanes kept toggle", 32'h3F80_00FF, 1'b1);

    // R6 new busy period restarts toggle
    @(negedge clk_i); busy_i = 4'h0;
    @(negedge clk_i); busy_i = 4'hF;
    #1 check("R6 restart per write cycle", 32'h3F80_00BF, 1'b1);

    @(negedge clk_i);
    finish_run();
  end
endmodule